// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block chooses which of the request lines of one interrupt controller is presented to the processor. Each cycle it receives the latched request word, the mask word, the in-service word, a rotation offset that sets which line currently has the highest priority, and three mode pins. From these it works out the best pending, unmasked line. It then asks whether that line outranks the highest-priority line already being serviced. If it does, a combinational hit flag and the winning line number are driven, and a registered interrupt output follows one clock later.

Priority is a position in a circular scan. Scan position 0 looks at line `rot_i`, position 1 looks at line `rot_i+1`, and so on, wrapping modulo the line count. A smaller position means a higher priority. The in-service word is scanned the same way, after two optional filters. In the special-mask mode, in-service lines that are also masked take no part in the comparison. In the nested mode, when the unit is a master, the cascade line's in-service bit is ignored. This lets a second request from the same slave through. Request latching, command decoding and vector formation are handled by neighbouring blocks. The interface carries register contents rather than a data stream, so every pin is a plain level and none has a handshake.

Top module: `prio_resolver`

## Requirements
- R1: A line is a candidate only when its request bit is 1 and its mask bit is 0. A line whose mask bit is 1 never wins.
- R2: Among the candidates, the winner is found at the smallest scan position p whose line (p + rot_i) mod 8 is a candidate. `line_o` equals that line number.
- R3: When there is no candidate, `hit_o` is 0 and `line_o` is 0.
- R4: `hit_o` is 1 only when the winner's scan position is strictly smaller than the scan position of the highest-priority in-service line. An in-service line of equal or higher priority blocks the request.
- R5: With the in-service word empty, any candidate produces `hit_o` = 1.
- R6: When `smm_en_i` is 1, in-service bits whose mask bit is 1 are removed before the in-service scan. When `smm_en_i` is 0, they are kept.
- R7: When `sfn_en_i` and `is_master_i` are both 1, in-service bit 2 (the cascade line) is excluded from the in-service scan. If either pin is 0, bit 2 counts like any other bit.
- R8: `irq_o` equals the value `hit_o` had at the previous rising clock edge. It therefore falls on the first edge after the winning condition disappears.
- R9: While `rst_n` is 0, `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Latched request word, one bit per line |
| mask_i | input | 8 | Mask word, 1 disables the line |
| insvc_i | input | 8 | In-service word |
| rot_i | input | 3 | Line holding the highest priority |
| smm_en_i | input | 1 | Special-mask mode enable |
| sfn_en_i | input | 1 | Nested mode enable (cascade exclusion) |
| is_master_i | input | 1 | 1 when this unit is the master |
| hit_o | output | 1 | A candidate outranks the in-service level |
| line_o | output | 3 | Winning line number, 0 when no hit |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default parameters: eight lines and the cascade at line 2. With these defaults every rotation offset and every position of the winner and the blocker relative to the wrap point can be reached in a short run. For each of the eight offsets, random request, mask and in-service words are applied with random mode pins, and every cycle is compared against a behavioural scan model. Directed cases pin down ties with the in-service level, the wrap from line 7 to line 0, both mode filters switched on and off, and the one-cycle lag and fall of the registered output.

// File: rtl/prio_res_pkg.sv
package prio_res_pkg;
  // filters applied to the in-service word before its priority scan
  typedef struct packed {
    logic drop_masked;   // special-mask mode
    logic drop_cascade;  // nested mode on a master unit
  } isr_filter_t;
endpackage

// File: rtl/prio_rot_scan.sv
module prio_rot_scan #(
  parameter int unsigned N = 8,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] vec_i,
  input  logic [W-1:0] rot_i,
  output logic [W:0]   prio_o,
  output logic [W-1:0] line_o
);
  localparam logic [W:0] NONE = (W+1)'(N);

  logic [2*N-1:0] dbl;
  logic [N-1:0]   rotv;

  // bit p of rotv is line (p + rot) mod N
  assign dbl  = {vec_i, vec_i};
  assign rotv = dbl[rot_i +: N];

  always_comb begin
    prio_o = NONE;
    for (int p = N - 1; p >= 0; p--) begin
      if (rotv[p]) prio_o = (W+1)'(p);
    end
  end

  assign line_o = prio_o[W-1:0] + rot_i;
endmodule

// File: rtl/prio_isr_filter.sv
module prio_isr_filter
  import prio_res_pkg::*;
#(
  parameter int unsigned N    = 8,
  parameter int unsigned CASC = 2
) (
  input  logic [N-1:0] insvc_i,
  input  logic [N-1:0] mask_i,
  input  isr_filter_t  mode_i,
  output logic [N-1:0] eff_o
);
  logic [N-1:0] after_mask;

  assign after_mask = mode_i.drop_masked ? (insvc_i & ~mask_i) : insvc_i;

  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      if (i == CASC) begin : g_casc
        assign eff_o[i] = after_mask[i] & ~mode_i.drop_cascade;
      end else begin : g_plain
        assign eff_o[i] = after_mask[i];
      end
    end
  endgenerate
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver
  import prio_res_pkg::*;
#(
  parameter int unsigned N    = 8,
  parameter int unsigned CASC = 2,
  localparam int unsigned W   = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] insvc_i,
  input  logic [W-1:0] rot_i,
  input  logic         smm_en_i,
  input  logic         sfn_en_i,
  input  logic         is_master_i,
  output logic         hit_o,
  output logic [W-1:0] line_o,
  output logic         irq_o
);
  logic [N-1:0] pend;
  logic [N-1:0] eff_isr;
  logic [W:0]   pend_prio, isr_prio;
  logic [W-1:0] pend_line, isr_line;
  isr_filter_t  fmode;
  logic         irq_q;

  assign pend               = req_i & ~mask_i;
  assign fmode.drop_masked  = smm_en_i;
  assign fmode.drop_cascade = sfn_en_i & is_master_i;

  prio_isr_filter #(.N(N), .CASC(CASC)) u_filt (
    .insvc_i (insvc_i),
    .mask_i  (mask_i),
    .mode_i  (fmode),
    .eff_o   (eff_isr)
  );

  prio_rot_scan #(.N(N)) u_pend_scan (
    .vec_i  (pend),
    .rot_i  (rot_i),
    .prio_o (pend_prio),
    .line_o (pend_line)
  );

  prio_rot_scan #(.N(N)) u_isr_scan (
    .vec_i  (eff_isr),
    .rot_i  (rot_i),
    .prio_o (isr_prio),
    .line_o (isr_line)
  );

  // empty pending scan yields N, which never beats any in-service level
  assign hit_o  = pend_prio < isr_prio;
  assign line_o = hit_o ? pend_line : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= hit_o;
  end
  assign irq_o = irq_q;

  // R1
  win_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (req_i[line_o] && !mask_i[line_o]));

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> (!hit_o && line_o == '0));

  // R4
  isr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && !smm_en_i && !(fmode.drop_cascade && line_o == W'(CASC)))
      |-> !insvc_i[line_o]);

  // R4
  isr_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && eff_isr != '0) |-> (line_o != isr_line));

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> irq_o);

  // R8
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |=> !irq_o);
endmodule

// File: tb/prio_resolver_bench.sv
module prio_resolver_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n;
  logic [7:0] req, msk, isv;
  logic [2:0] rot;
  logic       smm, sfn, mst;
  logic       hit, irq;
  logic [2:0] line;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  prio_resolver u_prio_resolver (
    .clk(clk), .rst_n(rst_n), .req_i(req), .mask_i(msk), .insvc_i(isv),
    .rot_i(rot), .smm_en_i(smm), .sfn_en_i(sfn), .is_master_i(mst),
    .hit_o(hit), .line_o(line), .irq_o(irq)
  );

  function automatic int scan(logic [7:0] v, int r);
    for (int p = 0; p < 8; p++) if (v[(p + r) % 8]) return p;
    return 8;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive one input set, check combinational outputs then the registered one
  task automatic apply(logic [7:0] r, logic [7:0] m, logic [7:0] i, int ro,
                       bit s, bit f, bit ms, string tag);
    logic [7:0] eff;
    int pp, ip, el;
    bit eh;
    @(negedge clk);
    req = r; msk = m; isv = i; rot = 3'(ro); smm = s; sfn = f; mst = ms;
    eff = i;
    if (s) eff = eff & ~m;
    if (f && ms) eff[2] = 1'b0;
    pp = scan(r & ~m, ro);
    ip = scan(eff, ro);
    eh = pp < ip;
    el = eh ? (pp + ro) % 8 : 0;
    #1;
    chk({tag, " hit"}, int'(hit), int'(eh));
    chk({tag, " line"}, int'(line), el);
    @(posedge clk);
    #1;
    chk("R8 irq", int'(irq), int'(eh));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req = 8'h01; msk = 8'h00; isv = 8'h00; rot = 3'd0;
    smm = 1'b0; sfn = 1'b0; mst = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 irq in reset", int'(irq), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R5: empty in-service, any candidate wins
    apply(8'h10, 8'h00, 8'h00, 0, 0, 0, 0, "R5");
    apply(8'h80, 8'h00, 8'h00, 5, 0, 0, 0, "R5");
    // R2: wrap of the scan
    apply(8'h81, 8'h00, 8'h00, 0, 0, 0, 0, "R2");
    apply(8'h81, 8'h00, 8'h00, 1, 0, 0, 0, "R2");
    apply(8'h22, 8'h00, 8'h00, 6, 0, 0, 0, "R2");
    // R1: masked lines never win
    apply(8'h0F, 8'h0F, 8'h00, 0, 0, 0, 0, "R1");
    apply(8'h0C, 8'h04, 8'h00, 0, 0, 0, 0, "R1");
    // R3: nothing pending
    apply(8'h00, 8'h00, 8'h00, 3, 0, 0, 0, "R3");
    // R4: equal or higher in-service blocks, lower does not
    apply(8'h08, 8'h00, 8'h08, 0, 0, 0, 0, "R4");
    apply(8'h08, 8'h00, 8'h02, 0, 0, 0, 0, "R4");
    apply(8'h08, 8'h00, 8'h20, 0, 0, 0, 0, "R4");
    apply(8'h08, 8'h00, 8'h02, 2, 0, 0, 0, "R4");
    // R6: special-mask filter
    apply(8'h08, 8'h02, 8'h02, 0, 1, 0, 0, "R6");
    apply(8'h08, 8'h02, 8'h02, 0, 0, 0, 0, "R6");
    // R7: cascade exclusion needs both pins
    apply(8'h10, 8'h00, 8'h04, 0, 0, 1, 1, "R7");
    apply(8'h10, 8'h00, 8'h04, 0, 0, 1, 0, "R7");
    apply(8'h04, 8'h00, 8'h04, 0, 0, 1, 1, "R7");
    apply(8'h04, 8'h00, 8'h04, 0, 0, 0, 1, "R7");
    // R8: rise then fall of the registered output
    apply(8'h01, 8'h00, 8'h00, 0, 0, 0, 0, "R8");
    apply(8'h01, 8'h01, 8'h00, 0, 0, 0, 0, "R8");

    // R2: every offset against the model with random words
    for (int r = 0; r < 8; r++) begin
      for (int k = 0; k < 200; k++) begin
        apply(8'($urandom), 8'($urandom), 8'($urandom & $urandom), r,
              1'($urandom), 1'($urandom), 1'($urandom), "R2 random");
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule